// File: doc/BRIEF.md
# Sampling Memory Counter with Pointer Readback

The block counts input pulses in a free-running binary counter and, on every sampling strobe, writes the present count into an internal memory. Entries are filled one after another in arrival order. The memory has a fixed capacity, 999 entries by default. Once it is full, the block ignores further strobes until it is cleared.

A host reads the stored values back through a pointer. While the pointer control is off, the read port shows the live count. While it is on, the read port shows the entry at the pointer address. Addresses that hold no valid entry read as zero.

The block also reports how many entries are held. A coincidence flag compares that number against a host preset, and a full flag marks a filled memory. An output-disable control empties the memory, and the host asserts it to start a new recording run. Strobes are expected to arrive far apart compared with the clock; the block uses only their rising edges.

Top module: `smc_top`

## Requirements
- R1: Each rising edge of `strobe_i` (low in the previous cycle, high now) writes the count register value at that clock edge into the next free entry. `entries_o` then rises by one. Entry 0 is written first.
- R2: The memory never holds more than DEPTH (default 999) entries. A strobe that arrives while DEPTH entries are held changes neither the entry count nor any stored entry.
- R3: With a nonzero `preset_i`, `coin_o` is high exactly when `entries_o` is greater than or equal to `preset_i`.
- R4: With `preset_i` equal to 0, `coin_o` stays low whatever the entry count.
- R5: While `out_dis_i` is high, the entry count is held at 0 and strobes are ignored. `coin_o` and `full_o` are low from the next clock edge on, and every entry that was stored before reads back as zero.
- R6: When `ptr_en_i` is low, `rd_data_o` shows the count. When it is high, `rd_data_o` shows the entry at `ptr_addr_i`. A change of these inputs reaches `rd_data_o` two clock edges later.
- R7: `full_o` goes high when the DEPTH-th entry is written and stays high until `out_dis_i` clears it.
- R8: A pointer address greater than or equal to `entries_o` reads as zero.
- R9: The count register resets to 0 and rises by one on each clock edge at which `pulse_i` is high. It wraps at 2^CNT_W.
- R10: After reset, `entries_o`, `coin_o`, `full_o` and `rd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Count pulse, one increment per high cycle |
| strobe_i | input | 1 | Sampling strobe, acts on its rising edge |
| ptr_en_i | input | 1 | Pointer readback enable |
| ptr_addr_i | input | ADDR_W (10) | Entry address for readback |
| out_dis_i | input | 1 | Output disable; clears entries, coincidence and full |
| preset_i | input | ADDR_W (10) | Entry-count preset for coincidence, 0 disables |
| rd_data_o | output | CNT_W (24) | Live count or addressed entry |
| entries_o | output | ADDR_W (10) | Number of stored entries |
| coin_o | output | 1 | Entry count has reached the preset |
| full_o | output | 1 | Memory holds DEPTH entries |

## Verification
The hardest state to reach is a completely full memory that then receives one more strobe. The stimulus gets there by alternating single count pulses with strobes 999 times, so that every entry holds a distinct value. It then strobes again and reads back the last entry and the entry count to show that nothing moved. A clear by output-disable follows, with a strobe applied during the clear. The bench then reads the old addresses to confirm that the earlier data no longer shows.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int unsigned CNT_W_DEF = 24;
  localparam int unsigned DEPTH_DEF = 999;
endpackage

// File: rtl/smc_counter.sv
module smc_counter #(
  parameter int unsigned CNT_W = smc_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (pulse_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/smc_store.sv
module smc_store #(
  parameter int unsigned CNT_W  = smc_pkg::CNT_W_DEF,
  parameter int unsigned DEPTH  = smc_pkg::DEPTH_DEF,
  parameter int unsigned ADDR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              rd_hit_o,
  output logic [ADDR_W-1:0] entries_o,
  output logic              full_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH);

  logic [CNT_W-1:0]  mem_q [DEPTH];
  logic [ADDR_W-1:0] entries_q;
  logic              strobe_q;
  logic              wr_en;
  logic              full;

  assign full  = (entries_q == LAST);
  assign wr_en = strobe_i & ~strobe_q & ~clear_i & ~full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q  <= 1'b0;
      entries_q <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (clear_i)    entries_q <= '0;
      else if (wr_en) entries_q <= entries_q + 1'b1;
    end
  end

  // storage needs no reset: validity is tracked by entries_q
  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[entries_q] <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rd_hit_o  <= 1'b0;
    end else begin
      rd_hit_o  <= (rd_addr_i < entries_q) & ~clear_i;
      rd_data_o <= (rd_addr_i < LAST) ? mem_q[rd_addr_i] : '0;
    end
  end

  assign entries_o = entries_q;
  assign full_o    = full;
endmodule

// File: rtl/smc_readout.sv
module smc_readout #(
  parameter int unsigned CNT_W = smc_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] mem_data_i,
  input  logic             mem_hit_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic             sel_q;
  logic [CNT_W-1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      live_q    <= '0;
      rd_data_o <= '0;
    end else begin
      sel_q  <= ptr_en_i;
      live_q <= cnt_i;
      if (!sel_q)         rd_data_o <= live_q;
      else if (mem_hit_i) rd_data_o <= mem_data_i;
      else                rd_data_o <= '0;
    end
  end
endmodule

// File: rtl/smc_top.sv
module smc_top #(
  parameter int unsigned CNT_W  = smc_pkg::CNT_W_DEF,
  parameter int unsigned DEPTH  = smc_pkg::DEPTH_DEF,
  parameter int unsigned ADDR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              strobe_i,
  input  logic              ptr_en_i,
  input  logic [ADDR_W-1:0] ptr_addr_i,
  input  logic              out_dis_i,
  input  logic [ADDR_W-1:0] preset_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [ADDR_W-1:0] entries_o,
  output logic              coin_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  mem_data;
  logic              mem_hit;
  logic [ADDR_W-1:0] entries;

  smc_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .cnt_o  (cnt)
  );

  smc_store #(.CNT_W(CNT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .clear_i  (out_dis_i),
    .cnt_i    (cnt),
    .rd_addr_i(ptr_addr_i),
    .rd_data_o(mem_data),
    .rd_hit_o (mem_hit),
    .entries_o(entries),
    .full_o   (full_o)
  );

  smc_readout #(.CNT_W(CNT_W)) i_readout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_en_i  (ptr_en_i),
    .cnt_i     (cnt),
    .mem_data_i(mem_data),
    .mem_hit_i (mem_hit),
    .rd_data_o (rd_data_o)
  );

  assign entries_o = entries;
  assign coin_o    = (preset_i != '0) && (entries >= preset_i);
endmodule

// File: rtl/smc_chk.sv
module smc_chk #(
  parameter int unsigned DEPTH  = smc_pkg::DEPTH_DEF,
  parameter int unsigned ADDR_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_dis_i,
  input logic [ADDR_W-1:0] preset_i,
  input logic [ADDR_W-1:0] entries_o,
  input logic              coin_o,
  input logic              full_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH);

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entries_o <= LAST);

  a_r1_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_dis_i |=> (entries_o == $past(entries_o)) || (entries_o == $past(entries_o) + 1'b1));

  a_r4_preset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_i == '0) |-> !coin_o);

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |=> (entries_o == '0) && !full_o);

  a_r7_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !out_dis_i) |=> full_o && $stable(entries_o));

  a_r2_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (entries_o == LAST));
endmodule

bind smc_top smc_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .out_dis_i(out_dis_i),
  .preset_i (preset_i),
  .entries_o(entries_o),
  .coin_o   (coin_o),
  .full_o   (full_o)
);

// File: tb/test_smc_top.sv
module test_smc_top;
  localparam int CNT_W  = 24;
  localparam int DEPTH  = 999;
  localparam int ADDR_W = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pulse_i = 1'b0;
  logic              strobe_i = 1'b0;
  logic              ptr_en_i = 1'b0;
  logic [ADDR_W-1:0] ptr_addr_i = '0;
  logic              out_dis_i = 1'b0;
  logic [ADDR_W-1:0] preset_i = '0;
  logic [CNT_W-1:0]  rd_data_o;
  logic [ADDR_W-1:0] entries_o;
  logic              coin_o;
  logic              full_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cnt_m = 0;
  int n_m = 0;
  int mem_m [DEPTH];

  always #2 clk_i = ~clk_i;

  smc_top i_smc_top (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) pulse_i = 1'b1;
      cnt_m++;
    end
    @(negedge clk_i) pulse_i = 1'b0;
  endtask

  task automatic do_strobe();
    @(negedge clk_i) strobe_i = 1'b1;
    if (!out_dis_i && n_m < DEPTH) begin
      mem_m[n_m] = cnt_m;
      n_m++;
    end
    @(negedge clk_i) strobe_i = 1'b0;
  endtask

  task automatic read_at(input bit ptr, input int addr, output int val);
    @(negedge clk_i);
    ptr_en_i   = ptr;
    ptr_addr_i = ADDR_W'(addr);
    repeat (3) @(negedge clk_i);
    val = int'(rd_data_o);
  endtask

  task automatic t_reset();
    check(entries_o == 0, "R10 entries", int'(entries_o), 0);
    check(!coin_o && !full_o, "R10 flags", int'({coin_o, full_o}), 0);
    check(rd_data_o == 0, "R10 rd_data", int'(rd_data_o), 0);
  endtask

  task automatic t_store_read();
    int v;
    for (int k = 0; k < 5; k++) begin
      do_pulse(k + 2);
      do_strobe();
    end
    @(negedge clk_i);
    check(int'(entries_o) == n_m, "R1 entry count", int'(entries_o), n_m);
    for (int k = 0; k < 5; k++) begin
      read_at(1'b1, k, v);
      check(v == mem_m[k], "R1 R6 entry value", v, mem_m[k]);
    end
    read_at(1'b1, 5, v);
    check(v == 0, "R8 addr at entry count", v, 0);
    read_at(1'b1, 900, v);
    check(v == 0, "R8 addr far beyond", v, 0);
  endtask

  task automatic t_live();
    int v;
    do_pulse(7);
    read_at(1'b0, 0, v);
    check(v == cnt_m, "R6 R9 live count", v, cnt_m);
    // two edges after enabling the pointer the entry must show
    @(negedge clk_i);
    ptr_en_i = 1'b1; ptr_addr_i = 2;
    @(negedge clk_i);
    @(negedge clk_i);
    check(int'(rd_data_o) == mem_m[2], "R6 latency", int'(rd_data_o), mem_m[2]);
    ptr_en_i = 1'b0;
  endtask

  task automatic t_coin();
    @(negedge clk_i) preset_i = ADDR_W'(n_m + 2);
    @(negedge clk_i);
    check(!coin_o, "R3 below preset", int'(coin_o), 0);
    do_pulse(1); do_strobe();
    @(negedge clk_i);
    check(!coin_o, "R3 one below", int'(coin_o), 0);
    do_pulse(1); do_strobe();
    @(negedge clk_i);
    check(coin_o, "R3 reached", int'(coin_o), 1);
    do_pulse(1); do_strobe();
    @(negedge clk_i);
    check(coin_o, "R3 above", int'(coin_o), 1);
  endtask

  task automatic t_preset0();
    @(negedge clk_i) preset_i = '0;
    @(negedge clk_i);
    check(!coin_o, "R4 preset zero", int'(coin_o), 0);
  endtask

  task automatic t_disable();
    int v;
    @(negedge clk_i) out_dis_i = 1'b1;
    do_strobe();
    @(negedge clk_i) out_dis_i = 1'b0;
    n_m = 0;
    @(negedge clk_i);
    check(entries_o == 0, "R5 entries cleared", int'(entries_o), 0);
    preset_i = 1;
    @(negedge clk_i);
    check(!coin_o, "R5 coin off", int'(coin_o), 0);
    read_at(1'b1, 0, v);
    check(v == 0, "R5 old entry hidden", v, 0);
    do_pulse(3); do_strobe();
    read_at(1'b1, 0, v);
    check(v == mem_m[0], "R5 R1 restart at entry 0", v, mem_m[0]);
    @(negedge clk_i) ptr_en_i = 1'b0; preset_i = '0;
  endtask

  task automatic t_full();
    int v;
    while (n_m < DEPTH) begin
      if (n_m == DEPTH - 1) begin
        @(negedge clk_i);
        check(!full_o, "R7 not yet full", int'(full_o), 0);
      end
      do_pulse(1);
      do_strobe();
    end
    @(negedge clk_i);
    check(full_o, "R7 full set", int'(full_o), 1);
    check(int'(entries_o) == DEPTH, "R2 count at limit", int'(entries_o), DEPTH);
    do_pulse(4);
    do_strobe();
    @(negedge clk_i);
    check(int'(entries_o) == DEPTH, "R2 extra strobe ignored", int'(entries_o), DEPTH);
    check(full_o, "R7 full holds", int'(full_o), 1);
    read_at(1'b1, DEPTH - 1, v);
    check(v == mem_m[DEPTH-1], "R2 last entry intact", v, mem_m[DEPTH-1]);
    read_at(1'b1, 0, v);
    check(v == mem_m[0], "R2 first entry intact", v, mem_m[0]);
    @(negedge clk_i) out_dis_i = 1'b1;
    @(negedge clk_i) out_dis_i = 1'b0;
    n_m = 0;
    check(!full_o && entries_o == 0, "R7 R5 full cleared", int'(full_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_store_read();
    t_live();
    t_coin();
    t_preset0();
    t_disable();
    t_full();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule